// File: doc/BRIEF.md
# Folded Four-Octave Wavelet Analysis Engine

This block performs a four-octave orthonormal wavelet decomposition of a continuous sample stream, taking one new input sample on every clock. Each octave splits its input into a highpass (detail) band and a lowpass band through a two-stage paraunitary lattice (third-order filters). The lowpass band of one octave feeds the next. Octave 1 needs a pair of samples every two clocks and has a lattice section to itself. Octaves 2, 3 and 4 need far less throughput, so they share a second, identical lattice section under a fixed 16-slot schedule.

Every lattice operation is pipelined. Each multiply takes four register stages and each add takes two. Sample pairs travel through the pipelines together with their octave number, so the state of each octave stays separate. The four detail bands and the final approximation are merged onto one output port, and each valid word carries a band tag. In steady state the five streams together fill every clock exactly: 8 + 4 + 2 + 1 + 1 words per 16 cycles.

Top module: `dwt_fold_analysis`

## Requirements
- R1: Every valid output word carries a band tag. Tags 1, 2, 3 and 4 mark the detail (highpass) bands of octaves 1 to 4, and tag 5 marks the final lowpass band of octave 4. No other tag value appears with the valid flag high.
- R2: Octave 1 forms pairs (e, o) from input samples 2n and 2n+1, counted from the first clock after reset release. Each lattice stage with coefficient c maps (p, q) to u = p + s(q) and v = s(p) - q. Here s(a) = (a*c) >>> 2, truncated to W bits, and all sums wrap at W bits. Stage 0 uses c0 = -7 (-1.75) on (e, o). Stage 1 uses c1 = 1 (0.25) on p = u0 and q = v0 of the previous pair of the same octave. The lowpass output is u1 and the highpass output is v1. The band-1 words appear in pair order.
- R3: Octave k (k = 2, 3, 4) applies the R2 lattice to pairs of consecutive lowpass results of octave k-1. Its highpass results appear in order as band k.
- R4: The lowpass results of octave 4 appear in order as band 5.
- R5: Reset clears the stored previous stage-0 result of every octave to zero. Reset also aligns pairing, so that the first sample after reset release is an even sample.
- R6: The valid flag is low during reset and for at least the first 12 clocks after reset release.
- R7: In steady state, the valid flag is high on every clock. Any 16-clock window then holds 8 band-1, 4 band-2, 2 band-3, 1 band-4 and 1 band-5 words. The two lattice sections never produce results in the same clock.
- R8: In steady state, the sequence of band tags repeats with a period of 16 clocks.
- R9: The shared section starts work only in even slots of the 16-slot frame. Octave 2 uses slots 0, 4, 8 and 12, octave 3 uses slots 2 and 10, and octave 4 uses slot 6.
- R10: No intermediate lowpass pair and no final lowpass result is overwritten before it has been issued or emitted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| x_in | input | W | Input sample, two's complement, one per clock |
| y_valid | output | 1 | Output word valid |
| y_tag | output | 3 | Band tag of the output word (1 to 5) |
| y_data | output | W | Output coefficient, two's complement |

## Verification
A bad stored stage-0 value or a pairing parity error in one octave corrupts that octave's band, and every lower-resolution band, from the next pair onward. Within a few output words this shows up as a mismatch against the arithmetic model of the stream. A lost or doubled pending pair shifts the whole stream of a band, so every later word in that band and in the bands below it mismatches. Schedule or merge faults show at the ports within one 16-clock frame: a gap in the valid flag, a tag count in the window that is off, or a tag sequence that does not repeat every 16 clocks.

// File: rtl/dwt_pkg.sv
`timescale 1ns/1ps
package dwt_pkg;
    localparam int OCT_W   = 2;   // octave code 0..3 (octave 1..4)
    localparam int TAG_W   = 3;
    localparam int FRAME_W = 4;   // 16-slot frame

    typedef enum logic [TAG_W-1:0] {
        TAG_NONE = 3'd0,
        TAG_HP1  = 3'd1,
        TAG_HP2  = 3'd2,
        TAG_HP3  = 3'd3,
        TAG_HP4  = 3'd4,
        TAG_LP4  = 3'd5
    } band_tag_e;

    // Slot table of the shared section: {issue, octave code}
    function automatic logic [2:0] slot_pick(input logic [FRAME_W-1:0] s);
        if (s[1:0] == 2'd0)      return 3'b1_01;
        else if (s[2:0] == 3'd2) return 3'b1_10;
        else if (s == 4'd6)      return 3'b1_11;
        else                     return 3'b0_01;
    endfunction
endpackage

// File: rtl/dwt_lattice_stage.sv
`timescale 1ns/1ps
module dwt_lattice_stage #(
    parameter int W       = 16,
    parameter int CW      = 4,
    parameter int FRAC    = 2,
    parameter int MUL_LAT = 4,
    parameter int ADD_LAT = 2,
    parameter int COEF    = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_vld,
    input  logic [dwt_pkg::OCT_W-1:0]   in_oct,
    input  logic signed [W-1:0]         in_p,
    input  logic signed [W-1:0]         in_q,
    output logic                        out_vld,
    output logic [dwt_pkg::OCT_W-1:0]   out_oct,
    output logic signed [W-1:0]         out_u,
    output logic signed [W-1:0]         out_v
);
    localparam logic signed [CW-1:0] COEF_S = CW'(COEF);

    typedef struct packed {
        logic                      vld;
        logic [dwt_pkg::OCT_W-1:0] oct;
        logic signed [W-1:0]       p;
        logic signed [W-1:0]       q;
        logic signed [W-1:0]       mp;
        logic signed [W-1:0]       mq;
    } mul_t;

    typedef struct packed {
        logic                      vld;
        logic [dwt_pkg::OCT_W-1:0] oct;
        logic signed [W-1:0]       u;
        logic signed [W-1:0]       v;
    } add_t;

    mul_t mul_q [MUL_LAT];
    mul_t mul_d [MUL_LAT];
    add_t add_q [ADD_LAT];
    add_t add_d [ADD_LAT];

    function automatic logic signed [W-1:0] scale(input logic signed [W-1:0] a);
        logic signed [W+CW-1:0] prod;
        logic signed [W+CW-1:0] shf;
        prod = a * COEF_S;
        shf  = prod >>> FRAC;
        return shf[W-1:0];
    endfunction

    always_comb begin
        mul_d[0].vld = in_vld;
        mul_d[0].oct = in_oct;
        mul_d[0].p   = in_p;
        mul_d[0].q   = in_q;
        mul_d[0].mp  = scale(in_p);
        mul_d[0].mq  = scale(in_q);
        for (int i = 1; i < MUL_LAT; i++) mul_d[i] = mul_q[i-1];

        add_d[0].vld = mul_q[MUL_LAT-1].vld;
        add_d[0].oct = mul_q[MUL_LAT-1].oct;
        add_d[0].u   = mul_q[MUL_LAT-1].p  + mul_q[MUL_LAT-1].mq;
        add_d[0].v   = mul_q[MUL_LAT-1].mp - mul_q[MUL_LAT-1].q;
        for (int i = 1; i < ADD_LAT; i++) add_d[i] = add_q[i-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MUL_LAT; i++) mul_q[i] <= '0;
            for (int i = 0; i < ADD_LAT; i++) add_q[i] <= '0;
        end else begin
            for (int i = 0; i < MUL_LAT; i++) mul_q[i] <= mul_d[i];
            for (int i = 0; i < ADD_LAT; i++) add_q[i] <= add_d[i];
        end
    end

    assign out_vld = add_q[ADD_LAT-1].vld;
    assign out_oct = add_q[ADD_LAT-1].oct;
    assign out_u   = add_q[ADD_LAT-1].u;
    assign out_v   = add_q[ADD_LAT-1].v;
endmodule

// File: rtl/dwt_lattice_section.sv
`timescale 1ns/1ps
module dwt_lattice_section #(
    parameter int W       = 16,
    parameter int CW      = 4,
    parameter int FRAC    = 2,
    parameter int MUL_LAT = 4,
    parameter int ADD_LAT = 2,
    parameter int C0      = -7,
    parameter int C1      = 1,
    parameter int NOCT    = 1,
    parameter int BASE    = 0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_vld,
    input  logic [dwt_pkg::OCT_W-1:0]   in_oct,
    input  logic signed [W-1:0]         in_e,
    input  logic signed [W-1:0]         in_o,
    output logic                        out_vld,
    output logic [dwt_pkg::OCT_W-1:0]   out_oct,
    output logic signed [W-1:0]         out_lo,
    output logic signed [W-1:0]         out_hi
);
    logic                        s0_vld;
    logic [dwt_pkg::OCT_W-1:0]   s0_oct;
    logic signed [W-1:0]         s0_u;
    logic signed [W-1:0]         s0_v;
    logic signed [W-1:0]         prev_sel;
    logic signed [W-1:0]         vprev_q [NOCT];
    logic signed [W-1:0]         vprev_d [NOCT];

    dwt_lattice_stage #(
        .W(W), .CW(CW), .FRAC(FRAC), .MUL_LAT(MUL_LAT), .ADD_LAT(ADD_LAT), .COEF(C0)
    ) u_stage0 (
        .clk(clk), .rst_n(rst_n),
        .in_vld(in_vld), .in_oct(in_oct), .in_p(in_e), .in_q(in_o),
        .out_vld(s0_vld), .out_oct(s0_oct), .out_u(s0_u), .out_v(s0_v)
    );

    // per-octave one-pair delay on the cross branch
    always_comb begin
        prev_sel = '0;
        for (int k = 0; k < NOCT; k++) begin
            vprev_d[k] = vprev_q[k];
            if (s0_oct == dwt_pkg::OCT_W'(BASE + k)) begin
                prev_sel = vprev_q[k];
                if (s0_vld) vprev_d[k] = s0_v;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NOCT; k++) vprev_q[k] <= '0;
        end else begin
            for (int k = 0; k < NOCT; k++) vprev_q[k] <= vprev_d[k];
        end
    end

    dwt_lattice_stage #(
        .W(W), .CW(CW), .FRAC(FRAC), .MUL_LAT(MUL_LAT), .ADD_LAT(ADD_LAT), .COEF(C1)
    ) u_stage1 (
        .clk(clk), .rst_n(rst_n),
        .in_vld(s0_vld), .in_oct(s0_oct), .in_p(s0_u), .in_q(prev_sel),
        .out_vld(out_vld), .out_oct(out_oct), .out_u(out_lo), .out_v(out_hi)
    );
endmodule

// File: rtl/dwt_fold_analysis.sv
`timescale 1ns/1ps
module dwt_fold_analysis #(
    parameter int W       = 16,
    parameter int CW      = 4,
    parameter int FRAC    = 2,
    parameter int MUL_LAT = 4,
    parameter int ADD_LAT = 2,
    parameter int C0      = -7,
    parameter int C1      = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  x_in,
    output logic          y_valid,
    output logic [2:0]    y_tag,
    output logic [W-1:0]  y_data
);
    import dwt_pkg::*;

    typedef struct packed {
        logic [FRAME_W-1:0]  cnt;
        logic [W-1:0]        x_even;
        logic [3:1]          par;
        logic [3:1]          pend_v;
        logic [3:1][W-1:0]   ehold;
        logic [3:1][W-1:0]   pend_e;
        logic [3:1][W-1:0]   pend_o;
        logic                hold_v;
        logic [W-1:0]        hold_val;
        logic                y_valid;
        logic [TAG_W-1:0]    y_tag;
        logic [W-1:0]        y_data;
    } state_t;

    state_t st_q, st_d;

    logic                a_vld;
    logic [W-1:0]        a_e, a_o;
    logic                a_out_vld;
    logic [OCT_W-1:0]    a_out_oct;
    logic signed [W-1:0] a_lo, a_hi;

    logic [2:0]          pick;
    logic                b_vld;
    logic [OCT_W-1:0]    b_oct;
    logic [W-1:0]        b_e, b_o;
    logic                b_out_vld;
    logic [OCT_W-1:0]    b_out_oct;
    logic signed [W-1:0] b_lo, b_hi;

    logic [3:1]          arr_v;
    logic [3:1][W-1:0]   arr_val;
    logic                lo4_v;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + FRAME_W'(1);

        // octave 1 pairing: even sample held, pair issued on odd clock
        if (!st_q.cnt[0]) st_d.x_even = x_in;
        a_vld = st_q.cnt[0];
        a_e   = st_q.x_even;
        a_o   = x_in;

        // shared section issue from slot table
        pick  = slot_pick(st_q.cnt);
        b_oct = pick[1:0];
        b_vld = pick[2] & st_q.pend_v[b_oct];
        b_e   = st_q.pend_e[b_oct];
        b_o   = st_q.pend_o[b_oct];
        if (b_vld) st_d.pend_v[b_oct] = 1'b0;

        // lowpass arrivals feeding octaves 2..4
        arr_v[1]   = a_out_vld && (a_out_oct == 2'd0);
        arr_val[1] = a_lo;
        arr_v[2]   = b_out_vld && (b_out_oct == 2'd1);
        arr_val[2] = b_lo;
        arr_v[3]   = b_out_vld && (b_out_oct == 2'd2);
        arr_val[3] = b_lo;
        lo4_v      = b_out_vld && (b_out_oct == 2'd3);

        for (int k = 1; k <= 3; k++) begin
            if (arr_v[k]) begin
                if (!st_q.par[k]) begin
                    st_d.ehold[k] = arr_val[k];
                    st_d.par[k]   = 1'b1;
                end else begin
                    st_d.pend_e[k] = st_q.ehold[k];
                    st_d.pend_o[k] = arr_val[k];
                    st_d.pend_v[k] = 1'b1;
                    st_d.par[k]    = 1'b0;
                end
            end
        end

        // output merge
        st_d.y_valid = 1'b0;
        st_d.y_tag   = TAG_NONE;
        st_d.y_data  = '0;
        if (a_out_vld) begin
            st_d.y_valid = 1'b1;
            st_d.y_tag   = TAG_HP1;
            st_d.y_data  = a_hi;
        end else if (b_out_vld) begin
            st_d.y_valid = 1'b1;
            st_d.y_tag   = {1'b0, b_out_oct} + 3'd1;
            st_d.y_data  = b_hi;
        end else if (st_q.hold_v) begin
            st_d.y_valid = 1'b1;
            st_d.y_tag   = TAG_LP4;
            st_d.y_data  = st_q.hold_val;
            st_d.hold_v  = 1'b0;
        end
        if (lo4_v) begin
            st_d.hold_v   = 1'b1;
            st_d.hold_val = b_lo;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    dwt_lattice_section #(
        .W(W), .CW(CW), .FRAC(FRAC), .MUL_LAT(MUL_LAT), .ADD_LAT(ADD_LAT),
        .C0(C0), .C1(C1), .NOCT(1), .BASE(0)
    ) u_sec_first (
        .clk(clk), .rst_n(rst_n),
        .in_vld(a_vld), .in_oct(2'd0), .in_e(a_e), .in_o(a_o),
        .out_vld(a_out_vld), .out_oct(a_out_oct), .out_lo(a_lo), .out_hi(a_hi)
    );

    dwt_lattice_section #(
        .W(W), .CW(CW), .FRAC(FRAC), .MUL_LAT(MUL_LAT), .ADD_LAT(ADD_LAT),
        .C0(C0), .C1(C1), .NOCT(3), .BASE(1)
    ) u_sec_shared (
        .clk(clk), .rst_n(rst_n),
        .in_vld(b_vld), .in_oct(b_oct), .in_e(b_e), .in_o(b_o),
        .out_vld(b_out_vld), .out_oct(b_out_oct), .out_lo(b_lo), .out_hi(b_hi)
    );

    assign y_valid = st_q.y_valid;
    assign y_tag   = st_q.y_tag;
    assign y_data  = st_q.y_data;
endmodule

// File: rtl/dwt_fold_analysis_chk.sv
`timescale 1ns/1ps
module dwt_fold_analysis_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       y_valid,
    input logic [2:0] y_tag,
    input logic       a_out_vld,
    input logic       b_out_vld,
    input logic       b_vld,
    input logic [1:0] b_oct,
    input logic [3:0] cnt,
    input logic [3:1] arr_v,
    input logic [3:1] par,
    input logic [3:1] pend_v,
    input logic       lo4_v,
    input logic       hold_v
);
    AST_TAG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        y_valid |-> (y_tag >= 3'd1 && y_tag <= 3'd5)); // R1
    AST_SECTIONS_INTERLEAVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_out_vld && b_out_vld)); // R7
    AST_SHARED_EVEN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        b_vld |-> !cnt[0]); // R9
    AST_OCT2_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (b_vld && b_oct == 2'd1) |-> (cnt[1:0] == 2'd0)); // R9
    AST_OCT3_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (b_vld && b_oct == 2'd2) |-> (cnt[2:0] == 3'd2)); // R9
    AST_OCT4_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (b_vld && b_oct == 2'd3) |-> (cnt == 4'd6)); // R9
    AST_NO_LOSS_OCT2: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_v[1] && par[1] && pend_v[1]) |-> (b_vld && b_oct == 2'd1)); // R10
    AST_NO_LOSS_OCT3: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_v[2] && par[2] && pend_v[2]) |-> (b_vld && b_oct == 2'd2)); // R10
    AST_NO_LOSS_OCT4: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_v[3] && par[3] && pend_v[3]) |-> (b_vld && b_oct == 2'd3)); // R10
    AST_NO_OVERWRITE_LP4: assert property (@(posedge clk) disable iff (!rst_n)
        lo4_v |-> !hold_v); // R10
endmodule

bind dwt_fold_analysis dwt_fold_analysis_chk u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .y_valid(y_valid),
    .y_tag(y_tag),
    .a_out_vld(a_out_vld),
    .b_out_vld(b_out_vld),
    .b_vld(b_vld),
    .b_oct(b_oct),
    .cnt(st_q.cnt),
    .arr_v(arr_v),
    .par(st_q.par),
    .pend_v(st_q.pend_v),
    .lo4_v(lo4_v),
    .hold_v(st_q.hold_v)
);

// File: tb/dwt_fold_analysis_test.sv
`timescale 1ns/1ps
module dwt_fold_analysis_test;
    localparam int W   = 16;
    localparam int NC  = 640;
    localparam int WD_CYCLES = 100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  x_in = '0;
    logic          y_valid;
    logic [2:0]    y_tag;
    logic [W-1:0]  y_data;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    int xs [NC];
    int ex [5][NC/2];
    int exn [5];
    int obs [5];
    int tags [NC];

    always #2.5 clk = ~clk;

    dwt_fold_analysis #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .x_in(x_in),
        .y_valid(y_valid), .y_tag(y_tag), .y_data(y_data)
    );

    function automatic int wrap(input int v);
        return int'(shortint'(v));
    endfunction

    function automatic int scl(input int a, input int c);
        return wrap((a * c) >>> 2);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // arithmetic model of the four octaves (R2, R3, R4, R5)
    task automatic build_model();
        int cur [NC];
        int nxt [NC];
        int len;
        len = NC;
        for (int i = 0; i < NC; i++) cur[i] = xs[i];
        for (int oc = 0; oc < 4; oc++) begin
            int prev;
            prev = 0;
            for (int n = 0; n < len / 2; n++) begin
                int e, o, u0, v0;
                e  = cur[2*n];
                o  = cur[2*n+1];
                u0 = wrap(e + scl(o, -7));
                v0 = wrap(scl(e, -7) - o);
                nxt[n]    = wrap(u0 + scl(prev, 1));
                ex[oc][n] = wrap(scl(u0, 1) - prev);
                prev = v0;
            end
            exn[oc] = len / 2;
            len = len / 2;
            for (int n = 0; n < len; n++) cur[n] = nxt[n];
        end
        for (int n = 0; n < len; n++) ex[4][n] = cur[n];
        exn[4] = len;
    endtask

    task automatic make_pattern(input int pid);
        logic [31:0] seed;
        seed = 32'h1234_5678 + 32'(pid);
        for (int i = 0; i < NC; i++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            case (pid)
                0: xs[i] = (i == 0) ? 64 : 0;
                1: xs[i] = (i % 50) - 25;
                2: xs[i] = (i % 2 == 0) ? 40 : -40;
                3: xs[i] = int'(seed[23:16]) - 128;
                4: xs[i] = 30;
                default: xs[i] = int'(shortint'(seed[31:16]));
            endcase
        end
    endtask

    task automatic run_pattern(input int pid);
        int win [6];
        make_pattern(pid);
        build_model();
        for (int b = 0; b < 5; b++) obs[b] = 0;

        rst_n = 1'b0;
        x_in  = '0;
        repeat (3) @(negedge clk);
        chk(y_valid == 1'b0, "R6 valid low in reset", int'(y_valid), 0);
        rst_n = 1'b1;
        x_in  = W'(xs[0]);
        for (int c = 1; c < NC; c++) begin
            @(negedge clk);
            tags[c] = y_valid ? int'(y_tag) : 0;
            if (c <= 12)
                chk(y_valid == 1'b0, "R6 valid low after reset", int'(y_valid), 0);
            if (c >= 200)
                chk(y_valid == 1'b1, "R7 valid every clock in steady state", int'(y_valid), 1);
            if (c >= 216)
                chk(tags[c] == tags[c-16], "R8 tag sequence period 16", tags[c], tags[c-16]);
            if (y_valid) begin
                if (y_tag < 3'd1 || y_tag > 3'd5) begin
                    chk(1'b0, "R1 tag range", int'(y_tag), 1);
                end else begin
                    int b, idx, act;
                    b   = int'(y_tag) - 1;
                    idx = obs[b];
                    act = int'($signed(y_data));
                    if (idx < exn[b]) begin
                        case (b)
                            0: chk(act == ex[b][idx], "R2 band1 octave1 detail", act, ex[b][idx]);
                            1, 2, 3: chk(act == ex[b][idx], "R3 band2..4 detail", act, ex[b][idx]);
                            default: chk(act == ex[b][idx], "R4 band5 final lowpass", act, ex[b][idx]);
                        endcase
                        if (idx == 0)
                            chk(act == ex[b][0], "R5 first word after reset", act, ex[b][0]);
                    end
                    obs[b]++;
                end
            end
            x_in = W'(xs[c]);
        end
        // R7 tag counts in one 16-clock window
        for (int b = 0; b <= 5; b++) win[b] = 0;
        for (int c = 256; c < 272; c++) win[tags[c]]++;
        chk(win[1] == 8, "R7 band1 count per window", win[1], 8);
        chk(win[2] == 4, "R7 band2 count per window", win[2], 4);
        chk(win[3] == 2, "R7 band3 count per window", win[3], 2);
        chk(win[4] == 1, "R7 band4 count per window", win[4], 1);
        chk(win[5] == 1, "R7 band5 count per window", win[5], 1);
        chk(obs[0] >= 300, "R2 band1 stream length", obs[0], 300);
        chk(obs[4] >= 30, "R4 band5 stream length", obs[4], 30);
    endtask

    initial begin
        for (int p = 0; p < 6; p++) run_pattern(p);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", WD_CYCLES, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule